// File: doc/BRIEF.md
# Pipelined Shift-Add Multiplier

This block multiplies two unsigned operands with a chain of identical shift-add slices. Each slice takes a triple: the remaining multiplier bits, the multiplicand and a running sum. It doubles the running sum. It adds the multiplicand when the top multiplier bit is set. It then moves the multiplier one place left. One slice runs per multiplier bit. A register follows every slice, so the longest combinational path is a single doubling and one add.

An input register captures each operand pair. An output register presents the finished product. With the default width of 5 bits, the path holds seven registers in all. A new pair may be offered on every clock edge. Once the chain is full, one product leaves on every edge. A valid flag travels with the data, so the output flag marks exactly the products that belong to accepted pairs. The block has no stall and no backpressure.

Top module: `pipe_mul5`

## Requirements
- R1: When `out_valid` is 1, `product` equals the unsigned product `op_a * op_b` of the pair that was accepted. This covers the extremes 0 and 31*31 = 961.
- R2: Latency is fixed. A pair is accepted on the rising edge where `in_valid` is 1. Its product and `out_valid` = 1 are visible right after the sixth rising edge that follows that capture edge, which is the seventh edge counting the capture edge.
- R3: The block accepts a pair on every consecutive edge. Back-to-back pairs give back-to-back products, each in the order it was accepted.
- R4: `out_valid` reproduces the `in_valid` pattern delayed by the R2 latency. An edge where `in_valid` is 0 makes no output, whatever `op_a` and `op_b` carry.
- R5: `rst` is synchronous and active high. After any rising edge where `rst` is 1, `out_valid` is 0 and `product` is 0. Pairs that were in flight when reset was sampled never produce `out_valid` = 1.
- R6: On an edge where no valid result reaches the output register, `product` keeps its previous value. Only finished products are ever shown.
- R7: The pair on the inputs is sampled only at the capture edge. Changing `op_a` or `op_b` on later cycles does not alter that pair's product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present this cycle |
| op_a | input | W (5) | Multiplier operand, unsigned |
| op_b | input | W (5) | Multiplicand operand, unsigned |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2W (10) | Unsigned product |

## Verification
A wrong slice, such as a dropped doubling or an add taken on the wrong bit, shows up as a wrong `product` exactly six edges after the faulty pair was captured. A flaw in the valid chain appears at the same edge, either as a missing `out_valid` or as a spurious one. A register that reset fails to clear becomes visible within seven edges, as a stale product or flag after the flush. A wrong output-register enable shows on the first empty slot, because `product` changes while `out_valid` is low.

// File: rtl/pipe_mul5.sv
module pipe_mul5 #(
  parameter int W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            out_valid,
  output logic [2*W-1:0]  product
);
  localparam int PW = 2 * W;

  logic [W:0]           v;
  logic [W:0][W-1:0]    a;
  logic [W:0][W-1:0]    b;
  logic [W:0][PW-1:0]   r;

  always_ff @(posedge clk) begin
    if (rst) begin
      v[0] <= 1'b0;
      a[0] <= '0;
      b[0] <= '0;
      r[0] <= '0;
    end else begin
      v[0] <= in_valid;
      a[0] <= op_a;
      b[0] <= op_b;
      r[0] <= '0;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic [PW-1:0] dbl, nxt;
    assign dbl = r[i] << 1;
    assign nxt = a[i][W-1] ? dbl + PW'(b[i]) : dbl;

    always_ff @(posedge clk) begin
      if (rst) begin
        v[i+1] <= 1'b0;
        a[i+1] <= '0;
        b[i+1] <= '0;
        r[i+1] <= '0;
      end else begin
        v[i+1] <= v[i];
        a[i+1] <= a[i] << 1;
        b[i+1] <= b[i];
        r[i+1] <= nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v[W];
      if (v[W]) product <= r[W];
    end
  end
endmodule

// File: rtl/pipe_mul5_chk.sv
module pipe_mul5_chk #(
  parameter int W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [W-1:0]    op_a,
  input logic [W-1:0]    op_b,
  input logic            out_valid,
  input logic [2*W-1:0]  product
);
  localparam int PW  = 2 * W;
  localparam int LAT = W + 2;

  logic [LAT-1:0]           sv;
  logic [LAT-1:0][PW-1:0]   sp;
  logic                     rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      sv <= '0;
      sp <= '0;
    end else begin
      sv[0] <= in_valid;
      sp[0] <= PW'(op_a) * PW'(op_b);
      for (int k = 1; k < LAT; k++) begin
        sv[k] <= sv[k-1];
        sp[k] <= sp[k-1];
      end
    end
  end

  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !rst_q) |-> product == sp[LAT-1]);

  a_r4_valid_track: assert property (@(posedge clk) disable iff (rst)
    !rst_q |-> out_valid == sv[LAT-1]);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !rst_q) |-> $stable(product));

  always_ff @(posedge clk) begin
    if (rst_q) begin
      a_r5_reset_clear: assert (!out_valid && product == '0);
    end
  end
endmodule

bind pipe_mul5 pipe_mul5_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .product(product)
);

// File: tb/test_pipe_mul5.sv
module test_pipe_mul5;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam int DLY = 6;
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {5'd31, 5'd31, 10'd961}, {5'd0,  5'd31, 10'd0},
    {5'd31, 5'd0,  10'd0},   {5'd1,  5'd1,  10'd1},
    {5'd16, 5'd16, 10'd256}, {5'd21, 5'd10, 10'd210},
    {5'd10, 5'd21, 10'd210}, {5'd31, 5'd1,  10'd31},
    {5'd1,  5'd31, 10'd31},  {5'd17, 5'd3,  10'd51},
    {5'd5,  5'd7,  10'd35},  {5'd30, 5'd29, 10'd870}
  };

  logic clk = 1'b0;
  logic rst, in_valid;
  logic [W-1:0] op_a, op_b;
  logic out_valid;
  logic [2*W-1:0] product;

  int checks = 0, fails = 0, cyc = 0;
  logic hv [0:1023];
  logic [2*W-1:0] hp [0:1023];
  logic [2*W-1:0] last_p;

  pipe_mul5 #(.W(W)) i_pipe_mul5 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic [2*W-1:0] ep, input string tag);
    rst = r; in_valid = v; op_a = a; op_b = b;
    @(posedge clk);
    cyc++;
    hv[cyc] = v & !r;
    hp[cyc] = ep;
    if (r) begin
      for (int k = 0; k < cyc; k++) hv[k] = 1'b0;
      last_p = '0;
    end
    #(CLK_PERIOD/2);
    if (r) begin
      chk({tag, " R5 valid"}, 32'(out_valid), 0);
      chk({tag, " R5 product"}, 32'(product), 0);
    end else if (cyc > DLY && hv[cyc-DLY]) begin
      chk({tag, " R2 valid"}, 32'(out_valid), 1);
      chk({tag, " R1 product"}, 32'(product), 32'(hp[cyc-DLY]));
      last_p = hp[cyc-DLY];
    end else begin
      chk({tag, " R4 no valid"}, 32'(out_valid), 0);
      chk({tag, " R6 hold"}, 32'(product), 32'(last_p));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++) begin hv[k] = 1'b0; hp[k] = '0; end
    last_p = '0;
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
    @(negedge clk);
    step(1, 0, 0, 0, 0, "reset");
    step(1, 1, 5'd9, 5'd9, 0, "reset");

    // R1 R3: table walked back to back
    for (int i = 0; i < NV; i++)
      step(0, 1, VEC[i][19:15], VEC[i][14:10], VEC[i][9:0], "R3 table");
    for (int i = 0; i < 8; i++) step(0, 0, 5'd31, 5'd31, 0, "R6 flush");

    // R4 R7: bubbles with garbage operands while in_valid is low
    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] x = W'(i * 3 + 1), y = W'(29 - i);
      if (i % 3 == 0) step(0, 1, x, y, 10'(x) * 10'(y), "R4 bubble");
      else step(0, 0, ~x, ~y, 0, "R7 garbage");
    end
    for (int i = 0; i < 8; i++) step(0, 0, 5'd7, 5'd7, 0, "R6 drain");

    // R5: reset while products are in flight
    for (int i = 0; i < 4; i++) step(0, 1, 5'd31, W'(i + 2), 10'd31 * 10'(i + 2), "R5 fill");
    step(1, 1, 5'd3, 5'd3, 0, "R5 midreset");
    for (int i = 0; i < 8; i++) step(0, 0, 5'd1, 5'd1, 0, "R5 after");

    // R1 R2: operand sweep
    for (int i = 0; i < 32; i++)
      step(0, 1, W'(i), W'(31 - i), 10'(i) * 10'(31 - i), "R1 sweep");
    for (int i = 0; i < 8; i++) step(0, 0, 5'd0, 5'd0, 0, "R2 tail");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule